// File: doc/BRIEF.md
# Autovectored Interrupt Priority Encoder

This block gathers interrupt requests from two groups of sources and turns each group into one shared interrupt line. Group A has 32 priority slots, four of which are reserved and can never fire. Group B has 14 slots: four programmable-level flags, four empty flags, four full flags, a waveform-complete event and a waveform-wait event. Each request is held in a sticky pending bit until software writes a 1 to that bit's clear strobe. Each source also has its own enable bit. A group's line is high whenever any of its pending bits is also enabled.

The block sits on the processor's instruction-fetch path. When the processor takes a group's interrupt, it fetches a three-byte jump instruction from that group's fixed entry address. If the group's autovector enable is set, the block replaces the low address byte of that jump with a vector byte. The vector is a multiple of 4 taken from the highest-priority enabled pending source. One 256-byte jump-table page can therefore send each source straight to its own handler. All other fetched bytes pass through unchanged.

The vector is captured in the cycle in which the entry byte is fetched. It then stays fixed while the remaining instruction bytes are read, so a request that arrives in the middle of the instruction cannot tear the jump target.

Top module: `irq_autovec`

## Requirements
- R1: After reset, all pending bits are clear and `irqA`/`irqB` are low. The captured vectors are the group bases: 0x00 for group A and 0x80 for group B.
- R2: A source input that is high for one cycle sets its pending bit at that clock edge. If the source is enabled, the group line is high from the next cycle on and stays high until the bit is cleared.
- R3: Driving a clear strobe bit to 1 clears that pending bit at the next edge. If a new request for the same bit arrives in that same cycle, the request wins and the bit stays set.
- R4: Each group line is the OR of its pending bits ANDed with their per-source enables. A pending bit whose enable is 0 does not raise the line, but it is kept and raises the line as soon as it is enabled.
- R5: In group A, the lowest-index enabled pending source wins. Its vector is 4 × index (index = slot − 1), so vectors run from 0x00 to 0x7C.
- R6: Group A indices 7, 17, 26 and 27 (vectors 0x1C, 0x44, 0x68, 0x6C) are reserved and never become pending.
- R7: In group B, the lowest-index enabled pending source wins. Its vector is 0x80 + 4 × index, from 0x80 to 0xB4. The index order is:
  - 0–3: programmable flags
  - 4–7: empty flags
  - 8–11: full flags
  - 12: waveform done
  - 13: waveform wait
- R8: A valid fetch at address 0x0045 returns the captured group A vector when `avEnA` is 1, and the memory byte when `avEnA` is 0.
- R9: A valid fetch at address 0x0055 returns the captured group B vector when `avEnB` is 1, and the memory byte when `avEnB` is 0.
- R10: A group's vector is captured in the cycle of a valid fetch at its entry address (0x0043 for A, 0x0053 for B). Requests that arrive later do not change it until the next entry fetch.
- R11: If no enabled source of a group is pending when the vector is captured, the captured vector is the group base (0x00 or 0x80).
- R12: A fetch at any other address, or any cycle with `fetchValid` low, returns `memData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcA | input | 32 | Group A request pulses, one per slot |
| srcB | input | 14 | Group B request pulses, one per slot |
| enA | input | 32 | Group A per-source enables |
| enB | input | 14 | Group B per-source enables |
| clrA | input | 32 | Group A write-1-to-clear strobes |
| clrB | input | 14 | Group B write-1-to-clear strobes |
| avEnA | input | 1 | Group A vector substitution enable |
| avEnB | input | 1 | Group B vector substitution enable |
| fetchValid | input | 1 | Instruction fetch in progress this cycle |
| fetchAddr | input | 16 | Fetch address |
| memData | input | 8 | Byte read from code memory |
| fetchData | output | 8 | Byte delivered to the processor |
| irqA | output | 1 | Group A shared interrupt line |
| irqB | output | 1 | Group B shared interrupt line |

## Verification
A pending bit that is stuck or lost shows on the group line one cycle after the pulse or the clear that should have changed it. It also shows up as a wrong vector byte at the third byte of the next jump fetch. A broken priority order or vector scaling appears directly as a wrong byte at 0x0045 or 0x0055. The checks cover several simultaneous-request patterns, both ends of each vector range, and the reserved slots. A vector register that tracks requests instead of holding its captured value is exposed by a higher-priority request injected between the entry fetch and the substituted byte.

// File: rtl/irq_autovec_pkg.sv
package irq_autovec_pkg;

  // Strobes produced by the fetch-address decoder for the datapath.
  typedef struct packed {
    logic captA;   // entry fetch of group A: capture vector
    logic captB;   // entry fetch of group B: capture vector
    logic subA;    // substitute group A vector on fetchData
    logic subB;    // substitute group B vector on fetchData
  } avecStrobe_t;

endpackage

// File: rtl/irq_autovec_ctrl.sv
module irq_autovec_ctrl
  import irq_autovec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ENTRY_A = 16'h0043,
  parameter logic [ADDR_W-1:0] ENTRY_B = 16'h0053,
  parameter int SUB_OFS = 2
) (
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              avEnA,
  input  logic              avEnB,
  output avecStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] SUB_A = ENTRY_A + ADDR_W'(SUB_OFS);
  localparam logic [ADDR_W-1:0] SUB_B = ENTRY_B + ADDR_W'(SUB_OFS);

  logic hitEntryA, hitEntryB, hitSubA, hitSubB;

  always_comb begin
    hitEntryA = (fetchAddr == ENTRY_A);
    hitEntryB = (fetchAddr == ENTRY_B);
    hitSubA   = (fetchAddr == SUB_A);
    hitSubB   = (fetchAddr == SUB_B);
    strobe.captA = fetchValid && hitEntryA;
    strobe.captB = fetchValid && hitEntryB;
    strobe.subA  = fetchValid && hitSubA && avEnA;
    strobe.subB  = fetchValid && hitSubB && avEnB;
  end

endmodule

// File: rtl/irq_autovec_group.sv
module irq_autovec_group #(
  parameter int N = 32,
  parameter int DATA_W = 8,
  parameter int STEP = 4,
  parameter logic [DATA_W-1:0] BASE = '0,
  parameter logic [N-1:0] RSVD_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      src,
  input  logic [N-1:0]      clr,
  input  logic [N-1:0]      en,
  input  logic              capt,
  output logic              irq,
  output logic [DATA_W-1:0] vecHeld
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      pend;
  logic [N-1:0]      active;
  logic [IW-1:0]     winIdx;
  logic [DATA_W-1:0] vecNow;

  // Sticky pending bits; a request in the same cycle as its clear wins.
  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else       pend <= ((pend & ~clr) | src) & ~RSVD_MASK;
  end

  assign active = pend & en;
  assign irq    = |active;

  // Fixed priority: the lowest index wins.
  always_comb begin
    winIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) winIdx = IW'(i);
    end
  end

  assign vecNow = BASE + DATA_W'(winIdx) * DATA_W'(STEP);

  always_ff @(posedge clk) begin
    if (!rstN)     vecHeld <= BASE;
    else if (capt) vecHeld <= vecNow;
  end

endmodule

// File: rtl/irq_autovec_dp.sv
module irq_autovec_dp
  import irq_autovec_pkg::*;
#(
  parameter int NUM_A = 32,
  parameter int NUM_B = 14,
  parameter int DATA_W = 8,
  parameter int STEP = 4,
  parameter logic [DATA_W-1:0] BASE_A = 8'h00,
  parameter logic [DATA_W-1:0] BASE_B = 8'h80,
  parameter logic [NUM_A-1:0] RSVD_A = 32'h0C02_0080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_A-1:0]  srcA,
  input  logic [NUM_B-1:0]  srcB,
  input  logic [NUM_A-1:0]  enA,
  input  logic [NUM_B-1:0]  enB,
  input  logic [NUM_A-1:0]  clrA,
  input  logic [NUM_B-1:0]  clrB,
  input  avecStrobe_t       strobe,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] fetchData,
  output logic              irqA,
  output logic              irqB
);

  logic [DATA_W-1:0] vecA, vecB;

  irq_autovec_group #(
    .N(NUM_A), .DATA_W(DATA_W), .STEP(STEP), .BASE(BASE_A), .RSVD_MASK(RSVD_A)
  ) u_grpA (
    .clk(clk), .rstN(rstN), .src(srcA), .clr(clrA), .en(enA),
    .capt(strobe.captA), .irq(irqA), .vecHeld(vecA)
  );

  irq_autovec_group #(
    .N(NUM_B), .DATA_W(DATA_W), .STEP(STEP), .BASE(BASE_B), .RSVD_MASK('0)
  ) u_grpB (
    .clk(clk), .rstN(rstN), .src(srcB), .clr(clrB), .en(enB),
    .capt(strobe.captB), .irq(irqB), .vecHeld(vecB)
  );

  always_comb begin
    if (strobe.subA)      fetchData = vecA;
    else if (strobe.subB) fetchData = vecB;
    else                  fetchData = memData;
  end

endmodule

// File: rtl/irq_autovec.sv
module irq_autovec
  import irq_autovec_pkg::*;
#(
  parameter int NUM_A = 32,
  parameter int NUM_B = 14,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int STEP = 4,
  parameter logic [ADDR_W-1:0] ENTRY_A = 16'h0043,
  parameter logic [ADDR_W-1:0] ENTRY_B = 16'h0053,
  parameter logic [DATA_W-1:0] BASE_A = 8'h00,
  parameter logic [DATA_W-1:0] BASE_B = 8'h80,
  parameter logic [NUM_A-1:0] RSVD_A = 32'h0C02_0080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_A-1:0]  srcA,
  input  logic [NUM_B-1:0]  srcB,
  input  logic [NUM_A-1:0]  enA,
  input  logic [NUM_B-1:0]  enB,
  input  logic [NUM_A-1:0]  clrA,
  input  logic [NUM_B-1:0]  clrB,
  input  logic              avEnA,
  input  logic              avEnB,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] fetchData,
  output logic              irqA,
  output logic              irqB
);

  avecStrobe_t strobe;

  irq_autovec_ctrl #(
    .ADDR_W(ADDR_W), .ENTRY_A(ENTRY_A), .ENTRY_B(ENTRY_B), .SUB_OFS(2)
  ) u_ctrl (
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .avEnA(avEnA), .avEnB(avEnB), .strobe(strobe)
  );

  irq_autovec_dp #(
    .NUM_A(NUM_A), .NUM_B(NUM_B), .DATA_W(DATA_W), .STEP(STEP),
    .BASE_A(BASE_A), .BASE_B(BASE_B), .RSVD_A(RSVD_A)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB), .enA(enA), .enB(enB),
    .clrA(clrA), .clrB(clrB), .strobe(strobe), .memData(memData),
    .fetchData(fetchData), .irqA(irqA), .irqB(irqB)
  );

endmodule

// File: rtl/irq_autovec_chk.sv
module irq_autovec_chk #(
  parameter int NUM_A = 32,
  parameter int NUM_B = 14,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ENTRY_A = 16'h0043,
  parameter logic [ADDR_W-1:0] ENTRY_B = 16'h0053,
  parameter logic [DATA_W-1:0] BASE_B = 8'h80
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_A-1:0]  srcA,
  input logic [NUM_B-1:0]  srcB,
  input logic [NUM_A-1:0]  enA,
  input logic [NUM_B-1:0]  enB,
  input logic [NUM_A-1:0]  clrA,
  input logic [NUM_B-1:0]  clrB,
  input logic              avEnA,
  input logic              avEnB,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [DATA_W-1:0] memData,
  input logic [DATA_W-1:0] fetchData,
  input logic              irqA,
  input logic              irqB
);

  localparam logic [ADDR_W-1:0] SUB_A = ENTRY_A + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] SUB_B = ENTRY_B + ADDR_W'(2);
  localparam logic [DATA_W-1:0] TOP_B = BASE_B + DATA_W'((NUM_B - 1) * 4);

  // R2: a raised line stays up unless cleared or its enables change
  p_sticky_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    (irqA && clrA == '0) |=> (irqA || enA != $past(enA)));
  p_sticky_b_r2: assert property (@(posedge clk) disable iff (!rstN)
    (irqB && clrB == '0) |=> (irqB || enB != $past(enB)));

  // R3: clearing every bit with no new request drops the line
  p_clear_a_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clrA == '1 && srcA == '0) |=> !irqA);
  p_clear_b_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clrB == '1 && srcB == '0) |=> !irqB);

  // R5: group A vectors are 4-aligned and below 0x80
  p_vec_a_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchAddr == SUB_A && avEnA) |->
      (fetchData[1:0] == 2'b00 && !fetchData[DATA_W-1]));

  // R6: reserved vectors never appear
  p_reserved_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchAddr == SUB_A && avEnA) |->
      (fetchData != 8'h1C && fetchData != 8'h44 &&
       fetchData != 8'h68 && fetchData != 8'h6C));

  // R7: group B vectors lie in the upper range
  p_vec_b_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchAddr == SUB_B && avEnB) |->
      (fetchData >= BASE_B && fetchData <= TOP_B && fetchData[1:0] == 2'b00));

  // R12: other addresses and idle cycles pass memory through
  p_pass_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid || (fetchAddr != SUB_A && fetchAddr != SUB_B)) |->
      (fetchData == memData));

endmodule

bind irq_autovec irq_autovec_chk #(
  .NUM_A(NUM_A), .NUM_B(NUM_B), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .ENTRY_A(ENTRY_A), .ENTRY_B(ENTRY_B), .BASE_B(BASE_B)
) u_chk (
  .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB), .enA(enA), .enB(enB),
  .clrA(clrA), .clrB(clrB), .avEnA(avEnA), .avEnB(avEnB),
  .fetchValid(fetchValid), .fetchAddr(fetchAddr), .memData(memData),
  .fetchData(fetchData), .irqA(irqA), .irqB(irqB)
);

// File: tb/irq_autovec_tb.sv
module irq_autovec_tb;
  localparam int NA = 32;
  localparam int NB = 14;
  localparam logic [15:0] ENT_A = 16'h0043;
  localparam logic [15:0] ENT_B = 16'h0053;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic [NA-1:0] srcA, enA, clrA;
  logic [NB-1:0] srcB, enB, clrB;
  logic          avEnA, avEnB, fetchValid;
  logic [15:0]   fetchAddr;
  logic [7:0]    memData, fetchData;
  logic          irqA, irqB;

  irq_autovec u_dut (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB), .enA(enA), .enB(enB),
    .clrA(clrA), .clrB(clrB), .avEnA(avEnA), .avEnB(avEnB),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .memData(memData),
    .fetchData(fetchData), .irqA(irqA), .irqB(irqB)
  );

  typedef struct {
    int         sel;   // 0 fetchData, 1 irqA, 2 irqB
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] vecA(int i); return 8'(i * 4); endfunction
  function automatic logic [7:0] vecB(int i); return 8'(8'h80 + i * 4); endfunction

  task automatic expectVal(int sel, logic [7:0] v, string r);
    item_t it;
    it.sel = sel; it.exp = v; it.req = r;
    q.push_back(it);
  endtask

  // Monitor: compares queued expectations mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = (it.sel == 0) ? fetchData : (it.sel == 1) ? {7'b0, irqA} : {7'b0, irqB};
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: got 0x%02h expected 0x%02h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic idle();
    srcA = '0; srcB = '0; clrA = '0; clrB = '0;
    fetchValid = 1'b0; fetchAddr = 16'h0100; memData = 8'hEE;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic pulseA(int i); tick(); srcA[i] = 1'b1; tick(); endtask
  task automatic pulseB(int i); tick(); srcB[i] = 1'b1; tick(); endtask
  task automatic clearA(logic [NA-1:0] m); tick(); clrA = m; tick(); endtask
  task automatic clearB(logic [NB-1:0] m); tick(); clrB = m; tick(); endtask

  task automatic jumpFetch(logic [15:0] entry, logic [7:0] expSub, string r);
    tick(); fetchValid = 1'b1; fetchAddr = entry;      memData = 8'h02;
    expectVal(0, 8'h02, r);
    tick(); fetchValid = 1'b1; fetchAddr = entry + 1;  memData = 8'h3C;
    expectVal(0, 8'h3C, r);
    tick(); fetchValid = 1'b1; fetchAddr = entry + 2;  memData = 8'hA5;
    expectVal(0, expSub, r);
    tick();
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    idle();
    enA = '1; enB = '1; avEnA = 1'b1; avEnB = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    tick();
    expectVal(1, 8'h00, "R1 irqA after reset");
    expectVal(2, 8'h00, "R1 irqB after reset");
    tick(); fetchValid = 1'b1; fetchAddr = 16'h0045; memData = 8'hA5;
    expectVal(0, 8'h00, "R1 group A vector after reset");
    tick(); fetchValid = 1'b1; fetchAddr = 16'h0055; memData = 8'hA5;
    expectVal(0, 8'h80, "R1 group B vector after reset");

    // R2: sticky request
    pulseA(5);
    expectVal(1, 8'h01, "R2 irqA after pulse");
    tick(); tick();
    expectVal(1, 8'h01, "R2 irqA held");
    jumpFetch(ENT_A, vecA(5), "R5 single source vector");

    // R5: priority among two
    pulseA(2);
    jumpFetch(ENT_A, vecA(2), "R5 lower index wins");

    // R3: clear
    clearA(32'h0000_0004);
    jumpFetch(ENT_A, vecA(5), "R3 cleared bit leaves next source");
    clearA(32'h0000_0020);
    expectVal(1, 8'h00, "R3 irqA low after last clear");

    // R6 + R11: reserved slots
    pulseA(7); pulseA(17); pulseA(26); pulseA(27);
    expectVal(1, 8'h00, "R6 reserved never pend");
    jumpFetch(ENT_A, 8'h00, "R11 base vector when nothing pending");

    // R4: enable gating keeps pending
    enA[9] = 1'b0;
    pulseA(9);
    expectVal(1, 8'h00, "R4 disabled source no irq");
    tick(); enA[9] = 1'b1;
    expectVal(1, 8'h01, "R4 pending retained then enabled");
    jumpFetch(ENT_A, vecA(9), "R5 vector index 9");
    clearA('1);

    // R3: set beats clear in the same cycle
    tick(); srcA[3] = 1'b1; clrA[3] = 1'b1;
    tick();
    expectVal(1, 8'h01, "R3 request wins over clear");
    jumpFetch(ENT_A, vecA(3), "R3 surviving bit vector");
    clearA('1);

    // R5: top slot
    pulseA(31);
    jumpFetch(ENT_A, 8'h7C, "R5 last slot vector");
    clearA('1);

    // R7: group B
    pulseB(12); pulseB(4);
    expectVal(2, 8'h01, "R7 irqB raised");
    jumpFetch(ENT_B, vecB(4), "R7 empty flag beats waveform done");
    clearB(14'h0010);
    jumpFetch(ENT_B, vecB(12), "R7 waveform done vector");
    pulseB(13);
    clearB(14'h1000);
    jumpFetch(ENT_B, 8'hB4, "R7 waveform wait top vector");
    pulseB(0);
    jumpFetch(ENT_B, 8'h80, "R7 first programmable flag");
    clearB('1);
    expectVal(2, 8'h00, "R3 irqB low after clear");

    // R8 / R9: substitution disabled
    pulseA(6); pulseB(1);
    avEnA = 1'b0; avEnB = 1'b0;
    jumpFetch(ENT_A, 8'hA5, "R8 autovector off passes memory");
    jumpFetch(ENT_B, 8'hA5, "R9 autovector off passes memory");
    avEnA = 1'b1; avEnB = 1'b1;
    jumpFetch(ENT_A, vecA(6), "R8 autovector on");
    jumpFetch(ENT_B, vecB(1), "R9 autovector on");

    // R12: other addresses and idle cycles
    tick(); fetchValid = 1'b1; fetchAddr = 16'h0046; memData = 8'h5A;
    expectVal(0, 8'h5A, "R12 neighbour address passes");
    tick(); fetchValid = 1'b0; fetchAddr = 16'h0045; memData = 8'h33;
    expectVal(0, 8'h33, "R12 no fetch passes");
    clearA('1); clearB('1);

    // R10: vector held through the instruction
    pulseA(20);
    tick(); fetchValid = 1'b1; fetchAddr = ENT_A; memData = 8'h02;
    tick(); fetchValid = 1'b1; fetchAddr = ENT_A + 1; memData = 8'h3C; srcA[1] = 1'b1;
    tick(); fetchValid = 1'b1; fetchAddr = ENT_A + 2; memData = 8'hA5;
    expectVal(0, vecA(20), "R10 vector held despite new request");
    tick();
    jumpFetch(ENT_A, vecA(1), "R10 next entry captures new winner");

    tick(); tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule